// File: doc/BRIEF.md
# Paged Peripheral Register Bridge

This block sits between a simple host register port and an external 8-bit peripheral whose internal register space is 64 bytes, addressed by six bits. The host sees a small set of local bridge registers at the bottom of its byte window. It also sees a 16-slot peripheral window that starts at byte 0xC0, with one slot every four bytes. An access to a window slot becomes a single strobed access on the peripheral side. The slot number supplies the low four bits of the peripheral register number. The two high bits come from the low two bits of an auxiliary output latch, so the host selects a page first and then reaches sixteen registers within it.

The bridge also holds an auxiliary pin direction register and an auxiliary output data register. It drives the peripheral's reset line from a control register. The peripheral's active-low interrupt pin passes through a two-flop synchroniser and can be read back as a status bit. That bit can also raise the bridge's interrupt output when a mask bit allows it. A host request is a one-cycle pulse. The bridge answers with a one-cycle `host_done` pulse, and read data is valid in that same cycle.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset, `per_rst` is 1, `aux_oe`, `aux_out` and `irq` are 0, `host_busy` is 0, and the ctrl register reads 0xFF.
- R2: A host access to byte address 0xC0 + 4*k (k = 0..15) reaches peripheral register {aux_out[1:0], k}. Host address bits 1:0 are ignored inside the window.
- R3: A window write produces exactly one `per_wr` strobe. The host write data is on `per_wdata` during that strobe, and `per_rd` stays low throughout.
- R4: A window read produces exactly one `per_rd` strobe. The value on `per_rdata` at the end of the strobe is returned on `host_rdata` together with `host_done`.
- R5: The peripheral address is driven one cycle before the strobe and is held for one cycle after it. The strobe lasts STROBE_CYC cycles (default 2). `host_done` comes 3+STROBE_CYC cycles after a window request and 1 cycle after a local request.
- R6: Byte 0x02 is the aux direction register and drives `aux_oe`. Bit 4 is the interrupt input, so it always stays 0 and reads back as 0. Byte 0x03 is the aux data register; it drives `aux_out` and reads back.
- R7: Writing 0xFF to the ctrl register at byte 0x00 sets `per_rst` to 1. Writing 0x00 or 0x40 sets it to 0. Any other value leaves it unchanged. The register reads back the last value written.
- R8: The status register at byte 0x07 shows the interrupt pin level on bit 4 (0 while an interrupt is pending), delayed by two clocks. All its other bits read 0.
- R9: Bit 4 of the mask register at byte 0x05 gates the interrupt. `irq` is 1 exactly when that bit is set and the synchronised pin is low. The mask register reads back in full.
- R10: A host request that arrives while `host_busy` is high is ignored. It causes no strobe and no register change.
- R11: Reads from unmapped bytes outside the window return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HA_W | Host byte address |
| host_wdata | input | D_W | Host write data |
| host_rdata | output | D_W | Read data, valid with host_done |
| host_done | output | 1 | Access complete pulse |
| host_busy | output | 1 | Peripheral access in progress |
| per_addr | output | PA_W | Peripheral register number |
| per_wdata | output | D_W | Peripheral write data |
| per_rdata | input | D_W | Peripheral read data |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_rst | output | 1 | Peripheral reset |
| per_irq_n | input | 1 | Peripheral interrupt, active low |
| aux_oe | output | AUX_W | Aux pin output enables |
| aux_out | output | AUX_W | Aux pin output data |
| irq | output | 1 | Masked interrupt to host |

## Verification
Random window reads and writes run against a peripheral model. Random slot numbers, random page values and random junk in address bits 1:0 show whether both halves of the split register number land in the right place and whether the ignored bits stay ignored. Directed local accesses exercise every reset-control code, including the two distinct release codes and values that must not act. The direction register's protected bit and the unmapped holes are written with all ones. The interrupt pin is toggled with and without the mask, and `irq` is sampled one and two cycles later, which separates a two-flop path from a shorter one. A request pulsed in the middle of a transfer must not add a strobe or disturb the target register.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD
   } seq_state_t;

   // local register byte offsets
   localparam int OFF_CTRL   = 'h00;
   localparam int OFF_AUXDIR = 'h02;
   localparam int OFF_AUXDAT = 'h03;
   localparam int OFF_MASK   = 'h05;
   localparam int OFF_STAT   = 'h07;

   // reset control codes
   localparam logic [7:0] RSTC_ASSERT  = 8'hFF;
   localparam logic [7:0] RSTC_REL_A   = 8'h00;
   localparam logic [7:0] RSTC_REL_B   = 8'h40;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_regs.sv
module bridge_regs
   import bridge_pkg::*;
#(
   parameter int HA_W    = 8,
   parameter int D_W     = 8,
   parameter int AUX_W   = 8,
   parameter int IRQ_BIT = 4,
   parameter int PG_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [HA_W-1:0]   addr,
   input  logic [D_W-1:0]    wdata,
   input  logic              irq_lvl,
   output logic [D_W-1:0]    rdata,
   output logic [AUX_W-1:0]  aux_oe,
   output logic [AUX_W-1:0]  aux_out,
   output logic [PG_W-1:0]   page,
   output logic              per_rst,
   output logic              irq
);
   localparam logic [AUX_W-1:0] IRQ_ONE = AUX_W'(1) << IRQ_BIT;

   logic [D_W-1:0]   ctrl_q;
   logic [D_W-1:0]   mask_q;
   logic [AUX_W-1:0] dir_q;
   logic [AUX_W-1:0] dat_q;
   logic             rst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= D_W'(RSTC_ASSERT);
         mask_q <= '0;
         dir_q  <= '0;
         dat_q  <= '0;
         rst_q  <= 1'b1;
      end else if (wr_en) begin
         if (addr == HA_W'(OFF_CTRL)) begin
            ctrl_q <= wdata;
            if (wdata == D_W'(RSTC_ASSERT))
               rst_q <= 1'b1;
            else if (wdata == D_W'(RSTC_REL_A) || wdata == D_W'(RSTC_REL_B))
               rst_q <= 1'b0;
         end
         if (addr == HA_W'(OFF_AUXDIR)) dir_q  <= wdata[AUX_W-1:0] & ~IRQ_ONE;
         if (addr == HA_W'(OFF_AUXDAT)) dat_q  <= wdata[AUX_W-1:0];
         if (addr == HA_W'(OFF_MASK))   mask_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == HA_W'(OFF_CTRL))   rdata = ctrl_q;
      if (addr == HA_W'(OFF_AUXDIR)) rdata = D_W'(dir_q);
      if (addr == HA_W'(OFF_AUXDAT)) rdata = D_W'(dat_q);
      if (addr == HA_W'(OFF_MASK))   rdata = mask_q;
      if (addr == HA_W'(OFF_STAT))   rdata = D_W'(irq_lvl) << IRQ_BIT;
   end

   assign aux_oe  = dir_q;
   assign aux_out = dat_q;
   assign page    = dat_q[PG_W-1:0];
   assign per_rst = rst_q;
   assign irq     = mask_q[IRQ_BIT] & ~irq_lvl;
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
   import bridge_pkg::*;
#(
   parameter int PA_W       = 6,
   parameter int D_W        = 8,
   parameter int STROBE_CYC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            we,
   input  logic [PA_W-1:0] paddr,
   input  logic [D_W-1:0]  wdata,
   input  logic [D_W-1:0]  per_rdata,
   output logic            busy,
   output logic            fin,
   output logic [D_W-1:0]  cap_data,
   output logic [PA_W-1:0] per_addr,
   output logic [D_W-1:0]  per_wdata,
   output logic            per_rd,
   output logic            per_wr
);
   localparam int CW = $clog2(STROBE_CYC + 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic          we_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         we_q      <= 1'b0;
         fin       <= 1'b0;
         cap_data  <= '0;
         per_addr  <= '0;
         per_wdata <= '0;
         per_rd    <= 1'b0;
         per_wr    <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               per_addr  <= paddr;
               per_wdata <= wdata;
               we_q      <= we;
               state     <= ST_SETUP;
            end
            ST_SETUP: begin
               per_rd <= ~we_q;
               per_wr <= we_q;
               cnt    <= CW'(STROBE_CYC - 1);
               state  <= ST_STROBE;
            end
            ST_STROBE: begin
               if (cnt == '0) begin
                  per_rd <= 1'b0;
                  per_wr <= 1'b0;
                  if (!we_q) cap_data <= per_rdata;
                  state <= ST_HOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD: begin
               fin   <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge #(
   parameter int HA_W        = 8,
   parameter int D_W         = 8,
   parameter int AUX_W       = 8,
   parameter int PA_W        = 6,
   parameter int LOW_W       = 4,
   parameter int WIN_BASE    = 'hC0,
   parameter int STROBE_CYC  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ_BIT     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req,
   input  logic             host_we,
   input  logic [HA_W-1:0]  host_addr,
   input  logic [D_W-1:0]   host_wdata,
   output logic [D_W-1:0]   host_rdata,
   output logic             host_done,
   output logic             host_busy,
   output logic [PA_W-1:0]  per_addr,
   output logic [D_W-1:0]   per_wdata,
   input  logic [D_W-1:0]   per_rdata,
   output logic             per_rd,
   output logic             per_wr,
   output logic             per_rst,
   input  logic             per_irq_n,
   output logic [AUX_W-1:0] aux_oe,
   output logic [AUX_W-1:0] aux_out,
   output logic             irq
);
   localparam int PG_W     = PA_W - LOW_W;
   localparam int WIN_SPAN = 1 << (LOW_W + 2);
   localparam int WIN_END  = WIN_BASE + WIN_SPAN;

   if (PG_W < 1 || PG_W > AUX_W) begin : g_bad_page
      $error("page width must be 1..AUX_W");
   end
   if (LOW_W + 2 > HA_W || WIN_END > (1 << HA_W)) begin : g_bad_win
      $error("window does not fit the host address space");
   end
   if (IRQ_BIT >= AUX_W || IRQ_BIT >= D_W || AUX_W > D_W) begin : g_bad_irq
      $error("interrupt bit or aux width out of range");
   end
   if (STROBE_CYC < 1 || SYNC_STAGES < 2) begin : g_bad_timing
      $error("strobe needs one cycle, synchroniser two stages");
   end

   logic              in_win;
   logic              accept;
   logic              seq_fin;
   logic [D_W-1:0]    seq_data;
   logic [D_W-1:0]    loc_rdata;
   logic [D_W-1:0]    loc_rdata_q;
   logic              loc_done_q;
   logic              irq_lvl;
   logic [PG_W-1:0]   page;

   assign in_win = ({1'b0, host_addr} >= (HA_W+1)'(WIN_BASE)) &&
                   ({1'b0, host_addr} <  (HA_W+1)'(WIN_END));
   assign accept = host_req & ~host_busy;

   bridge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(per_irq_n), .q(irq_lvl)
   );

   bridge_regs #(
      .HA_W(HA_W), .D_W(D_W), .AUX_W(AUX_W), .IRQ_BIT(IRQ_BIT), .PG_W(PG_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(accept & ~in_win & host_we),
      .addr(host_addr), .wdata(host_wdata), .irq_lvl(irq_lvl),
      .rdata(loc_rdata), .aux_oe(aux_oe), .aux_out(aux_out),
      .page(page), .per_rst(per_rst), .irq(irq)
   );

   bridge_seq #(.PA_W(PA_W), .D_W(D_W), .STROBE_CYC(STROBE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(accept & in_win), .we(host_we),
      .paddr({page, host_addr[LOW_W+1:2]}),
      .wdata(host_wdata), .per_rdata(per_rdata),
      .busy(host_busy), .fin(seq_fin), .cap_data(seq_data),
      .per_addr(per_addr), .per_wdata(per_wdata),
      .per_rd(per_rd), .per_wr(per_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_done_q  <= 1'b0;
         loc_rdata_q <= '0;
      end else begin
         loc_done_q  <= accept & ~in_win;
         loc_rdata_q <= (accept & ~in_win & ~host_we) ? loc_rdata : '0;
      end
   end

   assign host_done  = loc_done_q | seq_fin;
   assign host_rdata = seq_fin ? seq_data : loc_rdata_q;
endmodule

// File: rtl/paged_reg_bridge_chk.sv
module paged_reg_bridge_chk #(
   parameter int PA_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            per_rd,
   input logic            per_wr,
   input logic [PA_W-1:0] per_addr,
   input logic            busy,
   input logic            irq,
   input logic            per_irq_n
);
   logic strobe, strobe_d, rise_seen;
   assign strobe = per_rd | per_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_d  <= 1'b0;
         rise_seen <= 1'b0;
      end else begin
         strobe_d <= strobe;
         if (!busy) rise_seen <= 1'b0;
         else if (strobe && !strobe_d) rise_seen <= 1'b1;
      end
   end

   p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(per_rd && per_wr));

   p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !strobe_d) |-> !rise_seen);

   p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> $stable(per_addr));

   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && strobe_d) |=> $stable(per_addr));

   p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> busy);

   p_irq_from_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(!per_irq_n, 2));
endmodule

bind paged_reg_bridge paged_reg_bridge_chk #(.PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .per_rd(per_rd), .per_wr(per_wr),
   .per_addr(per_addr), .busy(host_busy), .irq(irq), .per_irq_n(per_irq_n)
);

// File: tb/paged_reg_bridge_test.sv
module paged_reg_bridge_test;
   localparam int CLK_PERIOD = 10;
   localparam int STROBE_CYC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_req = 1'b0, host_we = 1'b0;
   logic [7:0] host_addr = '0, host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_done, host_busy;
   logic [5:0] per_addr;
   logic [7:0] per_wdata, per_rdata;
   logic       per_rd, per_wr, per_rst;
   logic       per_irq_n = 1'b1;
   logic [7:0] aux_oe, aux_out;
   logic       irq;

   int errors = 0, checks = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   paged_reg_bridge #(.STROBE_CYC(STROBE_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_done(host_done), .host_busy(host_busy), .per_addr(per_addr),
      .per_wdata(per_wdata), .per_rdata(per_rdata), .per_rd(per_rd),
      .per_wr(per_wr), .per_rst(per_rst), .per_irq_n(per_irq_n),
      .aux_oe(aux_oe), .aux_out(aux_out), .irq(irq)
   );

   // peripheral model
   logic [7:0] mem [64];
   logic [7:0] exp_mem [64];
   int   n_rd = 0, n_wr = 0, cur_w = 0, last_w = 0;
   logic [5:0] last_addr;
   logic [7:0] last_wdata;
   logic       strobe_d = 1'b0;

   assign per_rdata = per_rd ? mem[per_addr] : 8'h00;

   always @(posedge clk) begin
      strobe_d <= per_rd | per_wr;
      if ((per_rd | per_wr) && !strobe_d) begin
         last_addr <= per_addr;
         if (per_wr) begin
            n_wr <= n_wr + 1;
            mem[per_addr] <= per_wdata;
            last_wdata <= per_wdata;
         end else n_rd <= n_rd + 1;
      end
      if (per_rd | per_wr) cur_w <= cur_w + 1;
      else if (strobe_d) begin last_w <= cur_w; cur_w <= 0; end
   end

   function automatic logic [5:0] win_target(logic [7:0] aux, logic [7:0] a);
      return {aux[1:0], a[5:2]};
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
      lat = 0;
      do begin
         @(posedge clk); @(negedge clk);
         host_req = 1'b0;
         lat++;
      end while (!host_done && lat < 50);
      rd = host_rdata;
   endtask

   logic [7:0] exp_aux = 8'h00;

   initial begin
      logic [7:0] rd;
      int lat, w0, r0;
      void'($urandom(32'd4711));
      for (int i = 0; i < 64; i++) begin
         mem[i] = 8'(i*7 + 3);
         exp_mem[i] = 8'(i*7 + 3);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 per_rst", per_rst, 1);
      check("R1 aux_oe", aux_oe, 0);
      check("R1 aux_out", aux_out, 0);
      check("R1 irq", irq, 0);
      check("R1 busy", host_busy, 0);
      access(1'b0, 8'h00, 8'h00, rd, lat);
      check("R1 ctrl readback", rd, 8'hFF);
      check("R5 local latency", lat, 1);

      // R7 reset control codes
      access(1'b1, 8'h00, 8'h40, rd, lat);
      check("R7 release 0x40", per_rst, 0);
      access(1'b1, 8'h00, 8'hFF, rd, lat);
      check("R7 assert 0xFF", per_rst, 1);
      access(1'b1, 8'h00, 8'h41, rd, lat);
      check("R7 other value keeps", per_rst, 1);
      access(1'b0, 8'h00, 8'h00, rd, lat);
      check("R7 readback", rd, 8'h41);
      access(1'b1, 8'h00, 8'h00, rd, lat);
      check("R7 release 0x00", per_rst, 0);
      access(1'b1, 8'h00, 8'h7E, rd, lat);
      check("R7 other value keeps released", per_rst, 0);

      // R6 aux registers
      access(1'b1, 8'h02, 8'hFF, rd, lat);
      check("R6 aux_oe irq bit input", aux_oe, 8'hEF);
      access(1'b0, 8'h02, 8'h00, rd, lat);
      check("R6 dir readback", rd, 8'hEF);
      access(1'b1, 8'h03, 8'hA6, rd, lat);
      exp_aux = 8'hA6;
      check("R6 aux_out", aux_out, 8'hA6);
      access(1'b0, 8'h03, 8'h00, rd, lat);
      check("R6 aux readback", rd, 8'hA6);

      // R11 unmapped holes
      foreach (rd[k]) ;
      access(1'b1, 8'h01, 8'hFF, rd, lat);
      access(1'b1, 8'h04, 8'hFF, rd, lat);
      access(1'b1, 8'h06, 8'hFF, rd, lat);
      access(1'b1, 8'h40, 8'hFF, rd, lat);
      check("R11 aux_out unchanged", aux_out, 8'hA6);
      check("R11 aux_oe unchanged", aux_oe, 8'hEF);
      check("R11 no strobe", n_wr + n_rd, 0);
      access(1'b0, 8'h01, 8'h00, rd, lat);
      check("R11 read 0x01", rd, 0);
      access(1'b0, 8'h40, 8'h00, rd, lat);
      check("R11 read 0x40", rd, 0);
      access(1'b0, 8'h05, 8'h00, rd, lat);
      check("R11 mask unchanged", rd, 0);

      // R2/R3/R4/R5 directed window accesses
      w0 = n_wr;
      access(1'b1, 8'hFF, 8'h5A, rd, lat);        // slot 15, junk low bits
      exp_mem[win_target(exp_aux, 8'hFF)] = 8'h5A;
      check("R5 window latency", lat, 3 + STROBE_CYC);
      check("R3 one write strobe", n_wr - w0, 1);
      check("R2 address page+slot", last_addr, 6'h2F);
      check("R3 write data", last_wdata, 8'h5A);
      check("R5 strobe width", last_w, STROBE_CYC);
      r0 = n_rd;
      access(1'b0, 8'hC1, 8'h00, rd, lat);        // slot 0 page 2
      check("R4 read data", rd, exp_mem[6'h20]);
      check("R4 one read strobe", n_rd - r0, 1);
      check("R4 no write strobe", n_wr - w0, 1);

      // random traffic
      for (int i = 0; i < 300; i++) begin
         int op;
         logic [7:0] a, d;
         logic [5:0] t;
         op = int'($urandom % 8);
         d  = 8'($urandom);
         a  = 8'hC0 | 8'($urandom % 64);
         if (op == 0) begin
            access(1'b1, 8'h03, d, rd, lat);
            exp_aux = d;
         end else if (op < 4) begin
            t = win_target(exp_aux, a);
            w0 = n_wr;
            access(1'b1, a, d, rd, lat);
            exp_mem[t] = d;
            check("R3 random write strobe", n_wr - w0, 1);
            check("R2 random write address", last_addr, t);
            check("R3 random write data", mem[t], d);
         end else begin
            t = win_target(exp_aux, a);
            r0 = n_rd;
            access(1'b0, a, 8'h00, rd, lat);
            check("R4 random read data", rd, exp_mem[t]);
            check("R2 random read address", last_addr, t);
            check("R5 random latency", lat, 3 + STROBE_CYC);
         end
      end

      // R10 request during busy ignored
      access(1'b1, 8'h03, 8'h00, rd, lat);
      exp_aux = 8'h00;
      w0 = n_wr;
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = 8'hC4; host_wdata = 8'h11;
      @(negedge clk);
      host_addr = 8'hC8; host_wdata = 8'h22;   // still high while busy
      @(negedge clk);
      host_req = 1'b0;
      host_addr = 8'h03; host_we = 1'b1; host_wdata = 8'h33;
      host_req = 1'b1;
      @(negedge clk);
      host_req = 1'b0;
      repeat (8) @(negedge clk);
      exp_mem[6'h01] = 8'h11;
      check("R10 single strobe", n_wr - w0, 1);
      check("R10 slot 2 untouched", mem[6'h02], exp_mem[6'h02]);
      check("R10 aux untouched", aux_out, 8'h00);

      // R8/R9 interrupt path
      access(1'b1, 8'h05, 8'h10, rd, lat);
      @(negedge clk);
      per_irq_n = 1'b0;
      @(negedge clk);
      check("R8 one flop not enough", irq, 0);
      @(negedge clk);
      check("R9 irq after two flops", irq, 1);
      access(1'b0, 8'h07, 8'h00, rd, lat);
      check("R8 status pending", rd, 8'h00);
      access(1'b1, 8'h05, 8'hEF, rd, lat);
      check("R9 masked off", irq, 0);
      access(1'b0, 8'h05, 8'h00, rd, lat);
      check("R9 mask readback", rd, 8'hEF);
      @(negedge clk);
      per_irq_n = 1'b1;
      repeat (3) @(negedge clk);
      access(1'b0, 8'h07, 8'h00, rd, lat);
      check("R8 status idle", rd, 8'h10);
      access(1'b1, 8'h05, 8'h10, rd, lat);
      check("R9 no irq when pin high", irq, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL R5 watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule